// File: doc/BRIEF.md
# Stereo Overrange Flag Multiplexer with Shared Timeout

This block turns per-sample overrange indications from a left and a right audio channel into a single active-low flag pin. The pin carries both channels' status, interleaved against the frame clock: during each half of the frame it presents one channel's flag. When either channel reports an overrange, the flags of both channels are asserted at once. They stay asserted for a fixed time measured in frames. Any new overrange on either channel restarts that time for both channels.

The pin does not change on the frame-clock transition itself. It changes a fixed number of bit-clock periods later: one in left-justified format and two in I2S format. The flag is therefore stable well before the next frame-clock edge. A receiver section in the same block latches the pin on every frame-clock transition. It routes the sample to the channel whose half has just ended and presents two separate active-high overflow outputs.

The whole block runs on one system clock. The bit clock arrives as a one-cycle strobe, `bit_stb`. The frame clock, `frame_clk`, is a level that changes only in a strobe cycle. The timeout is 2^`TMO_LOG2` frames in single-speed operation. It is doubled in double speed and quadrupled in quad speed, so the timeout stays the same length in seconds.

Top module: `stereo_ovr_flag`

## Requirements
- R1: While `rst` is high and in the first cycle after its release, `flag_n` is 1 and both `rx_ovf_left` and `rx_ovf_right` are 0.
- R2: An overrange pulse on `ovr_left` or on `ovr_right` marks the flags of both channels. The pin then drives 0 in both halves of the frame, and the receiver reports 1 on both overflow outputs.
- R3: In single speed (`speed_sel` = 00), the flags stay asserted until 2^`TMO_LOG2` rising frame-clock transitions have been counted after the last overrange. They clear on the last of those transitions. The first pin update after that drives 1.
- R4: An overrange that arrives while the flags are asserted restarts the count from zero for both channels. If an overrange and a rising frame-clock transition occur in the same strobe, the overrange wins.
- R5: `speed_sel` = 01 doubles the frame count and `speed_sel` = 10 quadruples it. The reserved code 11 behaves as single speed.
- R6: With `fmt_i2s` = 0 (left-justified), the pin updates only at the first bit strobe after the strobe that carries a frame-clock transition. At that update it takes the inverted flag of the channel owning the new half: left while `frame_clk` is 1, right while it is 0.
- R7: With `fmt_i2s` = 1 (I2S), the pin updates only at the second bit strobe after a frame-clock transition. Left owns the half where `frame_clk` is 0 and right owns the half where it is 1.
- R8: On every frame-clock transition, the receiver stores the inverted pin value. In left-justified format a rising transition stores into `rx_ovf_right` and a falling one into `rx_ovf_left`. In I2S format the mapping is reversed. Both outputs hold between transitions.
- R9: An overrange arriving after the pin update of a half leaves the pin unchanged until the next scheduled update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_stb | input | 1 | One-cycle strobe per bit-clock period |
| frame_clk | input | 1 | Frame-clock level, changes only with `bit_stb` |
| fmt_i2s | input | 1 | 0 = left-justified, 1 = I2S |
| speed_sel | input | 2 | 00 single, 01 double, 10 quad, 11 reserved (single) |
| ovr_left | input | 1 | Overrange pulse, left channel |
| ovr_right | input | 1 | Overrange pulse, right channel |
| flag_n | output | 1 | Time-multiplexed active-low flag pin |
| rx_ovf_left | output | 1 | Demultiplexed left overflow, active high |
| rx_ovf_right | output | 1 | Demultiplexed right overflow, active high |

## Verification
The bench builds the block with `TMO_LOG2` = 2. The timeout is then 4, 8 or 16 frames, so every speed code can be run through expiry and through a restart within a few dozen frames. It uses a 40-bit frame, which keeps each half longer than the setup window. A bench model advances the pin, the receiver and the frame count at every bit strobe. It covers both formats, an overrange landing exactly on a rising transition, and an overrange landing between pin updates.

// File: rtl/oflag_pkg.sv
package oflag_pkg;

    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_I2S = 1'b1
    } fmt_e;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_RSVD   = 2'b11
    } spd_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Frame-clock event seen on a bit strobe
    typedef struct packed {
        logic tick;   // frame clock changed on this strobe
        logic rise;   // change was low-to-high
        logic level;  // frame-clock level after the change
    } frame_evt_t;

    // Per-channel asserted state (active high inside the block)
    typedef struct packed {
        logic left;
        logic right;
    } chan_flags_t;

    localparam int unsigned DLY_W = 2;

    // Frame-count multiplier exponent for each speed code
    function automatic int unsigned spd_shift(spd_e s);
        case (s)
            SPD_DOUBLE: return 1;
            SPD_QUAD:   return 2;
            default:    return 0;
        endcase
    endfunction

    // Bit strobes between a frame transition and the pin update
    function automatic logic [DLY_W-1:0] update_delay(fmt_e f);
        return (f == FMT_I2S) ? 2'd2 : 2'd1;
    endfunction

    // Channel owning the half in which the frame clock has this level
    function automatic chan_e half_owner(fmt_e f, logic lvl);
        if (f == FMT_LJ) return lvl ? CH_LEFT : CH_RIGHT;
        else             return lvl ? CH_RIGHT : CH_LEFT;
    endfunction

    // Channel whose half has just closed, given the new level
    function automatic chan_e closing_chan(fmt_e f, logic new_lvl);
        return half_owner(f, ~new_lvl);
    endfunction

endpackage

// File: rtl/oflag_frame_edge.sv
module oflag_frame_edge
    import oflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb,
    input  logic       frame_clk,
    output frame_evt_t evt
);

    logic frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= 1'b0;
        end else if (bit_stb) begin
            frame_q <= frame_clk;
        end
    end

    always_comb begin
        evt.tick  = bit_stb && (frame_clk != frame_q);
        evt.rise  = evt.tick && frame_clk;
        evt.level = frame_clk;
    end

    AST_TICK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        evt.tick |-> bit_stb && !$stable(frame_clk)) else $error("frame tick without change"); // R6

endmodule

// File: rtl/oflag_timeout.sv
module oflag_timeout
    import oflag_pkg::*;
#(
    parameter int unsigned TMO_LOG2 = 15
) (
    input  logic        clk,
    input  logic        rst,
    input  spd_e        speed,
    input  frame_evt_t  evt,
    input  logic        ovr_left,
    input  logic        ovr_right,
    output chan_flags_t flags
);

    localparam int unsigned CNT_W = TMO_LOG2 + 3;

    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_idx;
    logic             ovr_any;

    always_comb begin
        ovr_any  = ovr_left || ovr_right;
        last_idx = CNT_W'((64'd1 << (TMO_LOG2 + spd_shift(speed))) - 64'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (ovr_any) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && evt.rise) begin
            if (cnt >= last_idx) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // One shared state drives both channel flags
    always_comb begin
        flags.left  = active;
        flags.right = active;
    end

    AST_OVR_ARMS: assert property (@(posedge clk) disable iff (rst)
        ovr_any |=> active && (cnt == '0)) else $error("overrange did not restart"); // R4

    AST_CLEAR_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(evt.rise)) else $error("cleared off a frame rise"); // R3

    AST_BOTH_CHANNELS: assert property (@(posedge clk) disable iff (rst)
        ovr_right |=> flags.left) else $error("right overrange missed left flag"); // R2

endmodule

// File: rtl/oflag_pin_mux.sv
module oflag_pin_mux
    import oflag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_stb,
    input  fmt_e        fmt,
    input  frame_evt_t  evt,
    input  chan_flags_t flags,
    output logic        flag_n
);

    logic [DLY_W-1:0] pend;
    chan_e            side;
    logic             sel_flag;

    always_comb begin
        sel_flag = (side == CH_LEFT) ? flags.left : flags.right;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= '0;
            side   <= CH_LEFT;
            flag_n <= 1'b1;
        end else if (evt.tick) begin
            pend <= update_delay(fmt);
            side <= half_owner(fmt, evt.level);
        end else if (bit_stb && (pend != '0)) begin
            pend <= pend - 1'b1;
            if (pend == DLY_W'(1)) begin
                flag_n <= ~sel_flag;
            end
        end
    end

    AST_PIN_QUIET_OFF_STROBE: assert property (@(posedge clk) disable iff (rst)
        !bit_stb |=> $stable(flag_n)) else $error("pin moved without strobe"); // R6

    AST_PIN_QUIET_ON_TRANSITION: assert property (@(posedge clk) disable iff (rst)
        evt.tick |=> $stable(flag_n)) else $error("pin moved on frame transition"); // R7

endmodule

// File: rtl/oflag_demux.sv
module oflag_demux
    import oflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fmt_e       fmt,
    input  frame_evt_t evt,
    input  logic       flag_n,
    output logic       rx_ovf_left,
    output logic       rx_ovf_right
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_ovf_left  <= 1'b0;
            rx_ovf_right <= 1'b0;
        end else if (evt.tick) begin
            if (closing_chan(fmt, evt.level) == CH_LEFT) begin
                rx_ovf_left <= ~flag_n;
            end else begin
                rx_ovf_right <= ~flag_n;
            end
        end
    end

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !evt.tick |=> $stable(rx_ovf_left) && $stable(rx_ovf_right)) else $error("receiver changed between edges"); // R8

endmodule

// File: rtl/stereo_ovr_flag.sv
module stereo_ovr_flag
    import oflag_pkg::*;
#(
    parameter int unsigned TMO_LOG2 = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_stb,
    input  logic       frame_clk,
    input  logic       fmt_i2s,
    input  logic [1:0] speed_sel,
    input  logic       ovr_left,
    input  logic       ovr_right,
    output logic       flag_n,
    output logic       rx_ovf_left,
    output logic       rx_ovf_right
);

    frame_evt_t  evt;
    chan_flags_t flags;
    fmt_e        fmt;
    spd_e        speed;

    always_comb begin
        fmt   = fmt_e'(fmt_i2s);
        speed = spd_e'(speed_sel);
    end

    oflag_frame_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .frame_clk (frame_clk),
        .evt       (evt)
    );

    oflag_timeout #(.TMO_LOG2(TMO_LOG2)) u_tmo (
        .clk       (clk),
        .rst       (rst),
        .speed     (speed),
        .evt       (evt),
        .ovr_left  (ovr_left),
        .ovr_right (ovr_right),
        .flags     (flags)
    );

    oflag_pin_mux u_mux (
        .clk     (clk),
        .rst     (rst),
        .bit_stb (bit_stb),
        .fmt     (fmt),
        .evt     (evt),
        .flags   (flags),
        .flag_n  (flag_n)
    );

    oflag_demux u_rx (
        .clk          (clk),
        .rst          (rst),
        .fmt          (fmt),
        .evt          (evt),
        .flag_n       (flag_n),
        .rx_ovf_left  (rx_ovf_left),
        .rx_ovf_right (rx_ovf_right)
    );

    AST_RESET_PIN_HIGH: assert property (@(posedge clk)
        $past(rst) |-> flag_n && !rx_ovf_left && !rx_ovf_right) else $error("reset state wrong"); // R1

endmodule

// File: tb/tb_stereo_ovr_flag.sv
`timescale 1ns/1ps
module tb_stereo_ovr_flag;

    localparam int unsigned LOG2 = 2;
    localparam int HALF = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_stb = 1'b0;
    logic       frame_clk = 1'b0;
    logic       fmt_i2s = 1'b0;
    logic [1:0] speed_sel = 2'b00;
    logic       ovr_left = 1'b0;
    logic       ovr_right = 1'b0;
    logic       flag_n;
    logic       rx_ovf_left;
    logic       rx_ovf_right;

    int checks = 0;
    int errors = 0;
    string pin_tag = "R6";

    // bench model state
    logic m_active, m_pin, m_rxl, m_rxr, m_prev;
    int   m_cnt, m_pend;

    always #2.5 clk = ~clk;

    stereo_ovr_flag #(.TMO_LOG2(LOG2)) dut (
        .clk(clk), .rst(rst), .bit_stb(bit_stb), .frame_clk(frame_clk),
        .fmt_i2s(fmt_i2s), .speed_sel(speed_sel), .ovr_left(ovr_left),
        .ovr_right(ovr_right), .flag_n(flag_n), .rx_ovf_left(rx_ovf_left),
        .rx_ovf_right(rx_ovf_right)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int frames_limit(input logic [1:0] s);
        case (s)
            2'b01:   return (1 << LOG2) * 2;
            2'b10:   return (1 << LOG2) * 4;
            default: return (1 << LOG2);
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_stb = 1'b0; frame_clk = 1'b0; ovr_left = 1'b0; ovr_right = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", flag_n, 1'b1);
        check("R1", rx_ovf_left, 1'b0);
        check("R1", rx_ovf_right, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", flag_n, 1'b1);
        check("R1", rx_ovf_left | rx_ovf_right, 1'b0);
        m_active = 0; m_pin = 1; m_rxl = 0; m_rxr = 0; m_prev = 0; m_cnt = 0; m_pend = 0;
    endtask

    // one bit strobe with optional overrange pulses, then model step and checks
    task automatic strobe(input logic lvl, input logic ol, input logic orr);
        logic trans;
        @(negedge clk);
        bit_stb = 1'b1; frame_clk = lvl; ovr_left = ol; ovr_right = orr;
        @(negedge clk);
        bit_stb = 1'b0; ovr_left = 1'b0; ovr_right = 1'b0;
        trans = (lvl != m_prev);
        // receiver latch uses the pin before this strobe
        if (trans) begin
            if ((lvl == 1'b1) != (fmt_i2s == 1'b1)) m_rxr = ~m_pin;  // LJ rise or I2S fall
            else                                     m_rxl = ~m_pin;
            m_pend = fmt_i2s ? 2 : 1;
        end else if (m_pend > 0) begin
            if (m_pend == 1) m_pin = ~m_active;
            m_pend--;
        end
        // shared timeout, overrange wins over counting
        if (ol || orr) begin
            m_active = 1; m_cnt = 0;
        end else if (trans && lvl && m_active) begin
            if (m_cnt >= frames_limit(speed_sel) - 1) begin m_active = 0; m_cnt = 0; end
            else m_cnt++;
        end
        m_prev = lvl;
        check(pin_tag, flag_n, m_pin);
        check("R8", rx_ovf_left, m_rxl);
        check("R8", rx_ovf_right, m_rxr);
        repeat (2) @(negedge clk);
    endtask

    // one frame: high half then low half; inj_* is bit index or -1
    task automatic frame(input int inj_l, input int inj_r);
        for (int b = 0; b < 2*HALF; b++) begin
            strobe(b < HALF, b == inj_l, b == inj_r);
        end
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) frame(-1, -1);
    endtask

    initial begin
        // R1 reset state
        do_reset();

        // left-justified, single speed: R6, R3
        fmt_i2s = 1'b0; speed_sel = 2'b00;
        pin_tag = "R6";
        frames(1);
        frame(25, -1);
        pin_tag = "R3";
        frames(6);
        check("R3", flag_n, 1'b1);

        // restart while asserted, right only: R4, R2
        pin_tag = "R4";
        frame(-1, 3);
        frames(1);
        check("R2", rx_ovf_left, 1'b1);
        check("R2", rx_ovf_right, 1'b1);
        check("R2", flag_n, 1'b0);
        frame(-1, 0);   // overrange on the same strobe as a rising transition
        frames(2);
        frame(30, -1);
        frames(6);
        check("R4", flag_n, 1'b1);

        // I2S double speed: R7, R5
        do_reset();
        fmt_i2s = 1'b1; speed_sel = 2'b01;
        pin_tag = "R7";
        frames(1);
        frame(7, -1);
        pin_tag = "R5";
        frames(10);
        check("R5", flag_n, 1'b1);

        // I2S quad speed: R5
        speed_sel = 2'b10;
        frame(-1, 22);
        frames(18);
        check("R5", rx_ovf_left | rx_ovf_right, 1'b0);

        // reserved speed code, left-justified: R5
        do_reset();
        fmt_i2s = 1'b0; speed_sel = 2'b11;
        pin_tag = "R5";
        frame(2, -1);
        frames(6);
        check("R5", flag_n, 1'b1);

        // R9: overrange after the update of a half leaves the pin alone
        do_reset();
        fmt_i2s = 1'b0; speed_sel = 2'b00;
        pin_tag = "R9";
        frames(1);
        strobe(1'b1, 1'b0, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        strobe(1'b1, 1'b1, 1'b0);
        for (int b = 3; b < HALF; b++) begin
            strobe(1'b1, 1'b0, 1'b0);
            check("R9", flag_n, 1'b1);
        end
        strobe(1'b0, 1'b0, 1'b0);
        check("R9", flag_n, 1'b1);
        strobe(1'b0, 1'b0, 1'b0);
        check("R6", flag_n, 1'b0);
        for (int b = 2; b < HALF; b++) strobe(1'b0, 1'b0, 1'b0);
        strobe(1'b1, 1'b0, 1'b0);
        check("R8", rx_ovf_right, 1'b1);
        check("R8", rx_ovf_left, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule